// File: doc/BRIEF.md
# Distributed Arithmetic FIR Filter

This block is an eight-tap FIR filter that forms its sum of products without a single multiplier. Signed samples enter a tapped delay line. For each accepted sample the block walks through the sample word one bit position per clock, from the sign bit down to the least significant bit. At every position it gathers that bit from four taps into a 4-bit address, reads a 16-entry table of precomputed coefficient sums, adds the two table outputs together, and folds the result into a doubling accumulator.

The partial sum for the sign-bit position is subtracted, which makes the result correct for two's complement samples. The two tables live in one long shift register. Software or a neighbouring controller rewrites them at run time by streaming bits through a one-bit load port, so new coefficients take effect without rebuilding the design. One sample is processed every B clocks, where B is the sample width, and the filter can take a new sample during the last bit clock of the current one.

Top module: `da_fir`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises: `out_valid` is 0, `out_data` is 0 and `in_ready` is 1. Reset also clears both tables and the delay line, so the first sample after reset yields 0.
- R2: Each result equals the sum over t = 0..7 of h_t · x(n−t), exactly, with no rounding. Here x(n−t) is the B-bit two's complement sample accepted t samples before the current one, with zeros after reset, and h_t is the coefficient of tap t.
- R3: `out_valid` is a one-clock pulse. It is high in the cycle that follows the B-th rising edge after the edge that accepted the sample. Every accepted sample yields exactly one pulse, and `out_data` does not change except on the edge that raises `out_valid`.
- R4: A sample is accepted on an edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 while a window is in progress, except during its final bit clock. A sample offered while `in_ready` is 0 is not taken and has no effect on any result.
- R5: When samples are offered continuously, they are accepted exactly B clocks apart.
- R6: The tables form one shift register of 2·16·TW bits. Each clock with `ld_en` high shifts in one `ld_bit`, and a full load takes 2·16·TW clocks. The bit order is: table 0 first, then table 1; within each table, entry 0 first; within each entry, LSB first.
  - Entry k of table g holds the TW-bit two's complement sum of h_(4g+i) over every i for which bit i of k is 1.
  - Tap 4g+i therefore drives address bit i of table g.
- R7: While `ld_en` is 1, `in_ready` is 0, a window in progress is frozen and no result is emitted. When `ld_en` falls, the window resumes where it stopped.
- R8: The output is TW+B+1 bits wide. Results at the extremes are exact, for example eight taps of −512 with samples of −128.
- R9: A reload takes effect for the next window, and the delay line keeps its contents across a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A sample is offered |
| in_ready | output | 1 | The filter can take a sample on this edge |
| in_data | input | B | Two's complement sample |
| out_valid | output | 1 | One-clock pulse marking a new result |
| out_data | output | TW+B+1 | Two's complement filter result |
| ld_en | input | 1 | Table shift enable; also stalls the filtering |
| ld_bit | input | 1 | Serial table bit |

## Verification
Each result is due exactly B rising edges after the edge that accepted its sample. The bench records the cycle of each acceptance, queues the arithmetically computed expectation, and compares `out_data` and that cycle distance on the falling edge where the pulse is visible. The one exception is a window stalled by a load: there the distance depends on when the stall began, so only the value is compared, while the load loop confirms that no pulse and no `in_ready` appear during the freeze. Streaming runs also measure the spacing between acceptances, and the bench confirms at the end that no queued result is left undelivered.

// File: rtl/da_fir.sv
module da_fir #(
  parameter int B  = 8,
  parameter int TW = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [B-1:0]       in_data,
  output logic               out_valid,
  output logic [TW+B:0]      out_data,
  input  logic               ld_en,
  input  logic               ld_bit
);
  localparam int TAPS  = 8;
  localparam int PER   = 4;
  localparam int NG    = TAPS / PER;
  localparam int ENT   = 1 << PER;
  localparam int NBITS = NG * ENT * TW;
  localparam int AW    = $clog2(NBITS);
  localparam int OW    = TW + B + 1;
  localparam int CW    = $clog2(B);

  logic [NBITS-1:0]      tbl;
  logic [B-1:0]          dly [TAPS];
  logic                  busy;
  logic [CW-1:0]         cnt;
  logic signed [OW-1:0]  acc;
  logic [CW-1:0]         bsel;
  logic                  last, take, step;
  logic signed [TW-1:0]  part [NG];
  logic signed [TW:0]    psum;
  logic signed [OW-1:0]  pext, acc_nx;

  assign bsel     = CW'(B - 1) - cnt;
  assign last     = busy && (cnt == CW'(B - 1));
  assign in_ready = !ld_en && (!busy || last);
  assign take     = in_valid && in_ready;
  assign step     = busy && !ld_en;

  for (genvar g = 0; g < NG; g++) begin : g_tbl
    logic [PER-1:0] addr;
    logic [AW-1:0]  base;
    for (genvar i = 0; i < PER; i++) begin : g_adr
      assign addr[i] = dly[g*PER+i][bsel];
    end
    assign base    = AW'((g * ENT + int'(addr)) * TW);
    assign part[g] = tbl[base +: TW];
  end

  always_comb begin
    psum = '0;
    for (int g = 0; g < NG; g++) psum = psum + (TW+1)'(part[g]);
  end

  assign pext   = OW'(psum);
  assign acc_nx = (cnt == '0) ? -pext : (acc <<< 1) + pext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tbl <= '0;
    else if (ld_en) tbl <= {ld_bit, tbl[NBITS-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < TAPS; t++) dly[t] <= '0;
    end else if (take) begin
      dly[0] <= in_data;
      for (int t = 1; t < TAPS; t++) dly[t] <= dly[t-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (take) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (step) begin
      busy <= !last;
      cnt  <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= step && last;
      if (step) acc <= acc_nx;
      if (step && last) out_data <= acc_nx;
    end
  end

  assert_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  assert_from_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(busy));
  assert_result_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));
  assert_refused_no_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> $stable(dly[0]));
  assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ld_en) |=> ($stable(cnt) && $stable(acc) && busy && !out_valid));
  assert_table_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |=> $stable(tbl));
endmodule

// File: tb/da_fir_test.sv
module da_fir_test;
  localparam int B  = 8;
  localparam int TW = 12;
  localparam int OW = TW + B + 1;

  logic clk = 0, rst_n = 0, in_valid = 0, ld_en = 0, ld_bit = 0;
  logic [B-1:0]  in_data = '0;
  logic          in_ready, out_valid;
  logic [OW-1:0] out_data;

  da_fir #(.B(B), .TW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .ld_en(ld_en), .ld_bit(ld_bit));

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, last_acc = -1;
  int coef [8];
  int hist [8];
  int expq[$], latq[$], accq[$];
  string tagq[$];
  bit prev_ov = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    int e, l, a, got;
    string tg;
    if (rst_n) begin
      if (out_valid) begin
        if (prev_ov) chk(0, "R3 pulse width", 1, 0);
        if (expq.size() == 0) chk(0, "R3 unexpected result", 1, 0);
        else begin
          e = expq.pop_front(); l = latq.pop_front();
          a = accq.pop_front(); tg = tagq.pop_front();
          got = int'($signed(out_data));
          chk(got == e, tg, got, e);
          if (l >= 0) chk(cyc - a == l, "R3 latency", cyc - a, l);
        end
      end
      prev_ov = out_valid;
    end
  end

  function automatic int model();
    int s = 0;
    for (int t = 0; t < 8; t++) s += coef[t] * hist[t];
    return s;
  endfunction

  task automatic send(input int v, input string tag, input int lat, input bit strm);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_data = B'(v);
    @(negedge clk);
    in_valid = 0;
    for (int t = 7; t > 0; t--) hist[t] = hist[t-1];
    hist[0] = v;
    if (strm && last_acc >= 0) chk(cyc - last_acc == B, "R5 spacing", cyc - last_acc, B);
    last_acc = cyc;
    expq.push_back(model()); latq.push_back(lat);
    accq.push_back(cyc); tagq.push_back(tag);
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic load_tables();
    bit bad = 0;
    for (int g = 0; g < 2; g++)
      for (int k = 0; k < 16; k++) begin
        int e = 0;
        for (int i = 0; i < 4; i++) if (((k >> i) & 1) == 1) e += coef[4*g+i];
        for (int j = 0; j < TW; j++) begin
          ld_en = 1; ld_bit = e[j];
          #1;
          if (in_ready || out_valid) bad = 1;
          @(negedge clk);
        end
      end
    ld_en = 0;
    chk(!bad, "R7 no ready or result during load", int'(bad), 0);
  endtask

  initial begin
    for (int t = 0; t < 8; t++) begin coef[t] = 0; hist[t] = 0; end
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R1 out_valid in reset", int'(out_valid), 0);
    chk(in_ready == 1, "R1 in_ready in reset", int'(in_ready), 1);
    chk(out_data == 0, "R1 out_data in reset", int'(out_data), 0);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0 && in_ready == 1, "R1 after release", int'(out_valid), 0);
    send(5, "R1 cleared tables", B, 0);
    drain();

    coef = '{101, -57, 3, 250, -511, 77, -1, 400};
    load_tables();
    send(1, "R6 impulse", B, 0);
    for (int i = 0; i < 7; i++) send(0, "R6 impulse tail", B, 0);
    drain();

    last_acc = -1;
    for (int v = -128; v < 128; v++) send(v, "R2 sweep", B, 1);
    drain();
    last_acc = -1;
    for (int v = 0; v < 40; v++) send((v * 37) % 256 - 128, "R2 scrambled", B, 1);
    drain();

    send(77, "R4 held-off window", B, 0);
    for (int i = 0; i < B - 1; i++) begin
      chk(in_ready == 0, "R4 ready low in window", int'(in_ready), 0);
      in_valid = 1; in_data = 8'h55;
      @(negedge clk);
    end
    in_valid = 0;
    send(-3, "R4 next after refusal", B, 0);
    drain();

    send(-100, "R7 stalled window", -1, 0);
    repeat (3) @(negedge clk);
    load_tables();
    send(42, "R7 after stall", B, 0);
    drain();

    coef = '{-300, 12, 45, -6, 200, 9, -88, 17};
    load_tables();
    send(19, "R9 new coefficients", B, 0);
    send(-64, "R9 second window", B, 0);
    drain();

    for (int t = 0; t < 8; t++) coef[t] = -512;
    load_tables();
    for (int i = 0; i < 8; i++) send(-128, "R8 neg extreme", B, 0);
    drain();
    for (int t = 0; t < 8; t++) coef[t] = 511;
    load_tables();
    for (int i = 0; i < 8; i++) send(127, "R8 pos extreme", B, 0);
    for (int i = 0; i < 8; i++) send(-128, "R8 mixed extreme", B, 0);
    drain();

    repeat (2 * B + 2) @(negedge clk);
    chk(expq.size() == 0, "R3 every sample answered", expq.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule